// File: doc/BRIEF.md
# Interrupt Exception Entry Sequencer

This block is the processor-side half of interrupt handling. An arbiter upstream has already picked one request and checked its priority. It presents a request line and a source event code. The sequencer holds the live status word and program counter, the two save registers and the two event registers. It also watches a strobe that marks the boundary between instructions.

When a request meets a boundary and the status word's block bit is clear, the block takes the interrupt, and every change lands in one clock edge. Both event registers receive the source code. The status word goes into the saved-status register and the program counter into the saved-PC register. The block, mode and bank bits of the status word are raised, and the interrupt mask field is left exactly as it was. The program counter jumps straight to the vector base plus 0x600.

A return strobe restores the status word and program counter from their save registers in one cycle. The rest of the pipeline can overwrite the live status word and program counter through two load ports whenever no entry or return is under way. The asynchronous active-low reset is released through a two-stage synchronizer, so every register-level effect appears two clock edges after `rst_n` rises.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is held, the outputs are: status word 0x700000F0 (block, bank and mode set, mask 0xF), program counter 0, both save registers 0, both event registers 0, and `irq_taken` low.
- R2: An interrupt is accepted at a clock edge only when `irq_req`, `insn_brk` and not `rte_req` all hold and status bit 28 (block) is 0. On acceptance `irq_taken` is high for exactly the following cycle.
- R3: On acceptance, `evt_q` and `evt2_q` both take the value of `irq_code`.
- R4: On acceptance, `ssr_q` takes the prior status word and `spc_q` takes the prior program counter.
- R5: On acceptance, status bits 28 (block), 29 (bank) and 30 (mode) are set to 1.
- R6: On acceptance, `pc_q` becomes `vbr + 0x600`, modulo 2^32, at the same edge.
- R7: Acceptance leaves every other status bit unchanged, including the 4-bit mask field at bits 7:4.
- R8: While status bit 28 is 1, a request at a boundary is ignored. The status word, program counter, save registers and event registers keep their values, and `irq_taken` stays low.
- R9: A cycle with `rte_req` high loads the status word from `ssr_q` and the program counter from `spc_q` at the next edge.
- R10: When `rte_req` and an acceptable request arrive in the same cycle, only the return happens. The request is not latched and can be accepted at a later boundary.
- R11: `sr_ld` and `pc_ld` write `sr_ld_data` and `pc_ld_data` only in cycles with neither an acceptance nor a return. An acceptance or a return overrides them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Arbitrated interrupt request |
| irq_code | input | 12 | Event code of the requesting source |
| insn_brk | input | 1 | Instruction-boundary strobe |
| rte_req | input | 1 | Return-from-exception strobe |
| vbr | input | 32 | Vector base register value |
| sr_ld | input | 1 | Pipeline write enable for the status word |
| sr_ld_data | input | 32 | Status word write data |
| pc_ld | input | 1 | Pipeline write enable for the program counter |
| pc_ld_data | input | 32 | Program counter write data |
| sr_q | output | 32 | Live status word |
| pc_q | output | 32 | Live program counter |
| ssr_q | output | 32 | Saved status word |
| spc_q | output | 32 | Saved program counter |
| evt_q | output | 12 | Primary event register |
| evt2_q | output | 12 | Secondary event register |
| irq_taken | output | 1 | One-cycle pulse after acceptance |

## Verification
The bench drives requests that arrive off a boundary and requests that arrive while the block bit is set. A design that accepted either of these would jump to the handler in the middle of an instruction, or would overwrite the save registers of a handler already running. It varies the mask field and the vector base, including a base that wraps past 2^32. An entry that cleared or lowered the mask, or that added the offset at the wrong width, would show up in `sr_q` or `pc_q`. It also lines up a return with an acceptable request in the same cycle, and a status load with an entry. A design that let the entry win would overwrite `ssr_q`/`spc_q` and lose the return context, and one that let the load win would leave the block bit clear inside the handler.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_ENTER  = 2'd1,
    OP_RETURN = 2'd2
  } exc_op_e;
endpackage

// File: rtl/exc_accept_ctl.sv
module exc_accept_ctl
  import exc_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int BL_POS = 28
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_req,
  input  logic            insn_brk,
  input  logic            rte_req,
  input  logic [XLEN-1:0] sr_cur,
  output exc_op_e         op,
  output logic            irq_taken
);
  logic accept_ok;
  logic taken_d;
  logic taken_q;

  always_comb begin
    accept_ok = irq_req && insn_brk && !sr_cur[BL_POS];
    if (rte_req)        op = OP_RETURN;   // return takes precedence (R10)
    else if (accept_ok) op = OP_ENTER;
    else                op = OP_NONE;
    taken_d = (op == OP_ENTER);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taken_q <= 1'b0;
    else        taken_q <= taken_d;
  end

  assign irq_taken = taken_q;

  // R2: a pulse only ever follows a boundary strobe
  a_r2_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
    irq_taken |-> $past(insn_brk) && $past(irq_req));
  // R8: block bit set means nothing is taken
  a_r8_block_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    sr_cur[BL_POS] |=> !irq_taken);
  // R10: a return cycle never produces an acceptance pulse
  a_r10_return_first: assert property (@(posedge clk) disable iff (!rst_n)
    rte_req |=> !irq_taken);
endmodule

// File: rtl/exc_save_bank.sv
module exc_save_bank
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int EVW  = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  exc_op_e         op,
  input  logic [XLEN-1:0] sr_cur,
  input  logic [XLEN-1:0] pc_cur,
  input  logic [EVW-1:0]  code,
  output logic [XLEN-1:0] ssr_q,
  output logic [XLEN-1:0] spc_q,
  output logic [EVW-1:0]  evt_q,
  output logic [EVW-1:0]  evt2_q
);
  logic            save_en;
  logic [XLEN-1:0] ssr_d, spc_d;
  logic [EVW-1:0]  evt_d, evt2_d;

  always_comb begin
    save_en = (op == OP_ENTER);
    ssr_d   = save_en ? sr_cur : ssr_q;
    spc_d   = save_en ? pc_cur : spc_q;
    evt_d   = save_en ? code   : evt_q;
    evt2_d  = save_en ? code   : evt2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ssr_q  <= '0;
      spc_q  <= '0;
      evt_q  <= '0;
      evt2_q <= '0;
    end else begin
      ssr_q  <= ssr_d;
      spc_q  <= spc_d;
      evt_q  <= evt_d;
      evt2_q <= evt2_d;
    end
  end

  // R4: context saved from the live registers
  a_r4_context_saved: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ENTER) |=> (ssr_q == $past(sr_cur)) && (spc_q == $past(pc_cur)));
  // R3: both event registers agree after an entry
  a_r3_event_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ENTER) |=> (evt_q == $past(code)) && (evt2_q == evt_q));
  // R8: save bank is stable when nothing enters
  a_r8_bank_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_ENTER) |=> $stable(ssr_q) && $stable(spc_q) && $stable(evt_q));
endmodule

// File: rtl/exc_live_regs.sv
module exc_live_regs
  import exc_entry_pkg::*;
#(
  parameter int              XLEN    = 32,
  parameter int              BL_POS  = 28,
  parameter int              RB_POS  = 29,
  parameter int              MD_POS  = 30,
  parameter logic [XLEN-1:0] VEC_OFS = 'h600,
  parameter logic [XLEN-1:0] SR_RST  = 'h7000_00F0,
  parameter logic [XLEN-1:0] PC_RST  = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  exc_op_e         op,
  input  logic [XLEN-1:0] vbr,
  input  logic [XLEN-1:0] ssr,
  input  logic [XLEN-1:0] spc,
  input  logic            sr_ld,
  input  logic [XLEN-1:0] sr_ld_data,
  input  logic            pc_ld,
  input  logic [XLEN-1:0] pc_ld_data,
  output logic [XLEN-1:0] sr_q,
  output logic [XLEN-1:0] pc_q
);
  localparam logic [XLEN-1:0] ONE      = {{(XLEN-1){1'b0}}, 1'b1};
  localparam logic [XLEN-1:0] SET_MASK = (ONE << BL_POS) | (ONE << RB_POS) | (ONE << MD_POS);

  logic [XLEN-1:0] sr_d, pc_d;

  always_comb begin
    sr_d = sr_q;
    pc_d = pc_q;
    unique case (op)
      OP_RETURN: begin
        sr_d = ssr;
        pc_d = spc;
      end
      OP_ENTER: begin
        sr_d = sr_q | SET_MASK;
        pc_d = vbr + VEC_OFS;
      end
      default: begin
        if (sr_ld) sr_d = sr_ld_data;
        if (pc_ld) pc_d = pc_ld_data;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= SR_RST;
      pc_q <= PC_RST;
    end else begin
      sr_q <= sr_d;
      pc_q <= pc_d;
    end
  end

  // R5: control bits raised on entry
  a_r5_ctrl_bits_set: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ENTER) |=> sr_q[BL_POS] && sr_q[RB_POS] && sr_q[MD_POS]);
  // R7: all other status bits, mask included, untouched by entry
  a_r7_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ENTER) |=> ((sr_q & ~SET_MASK) == ($past(sr_q) & ~SET_MASK)));
  // R6: handler address taken immediately
  a_r6_handler_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ENTER) |=> (pc_q == $past(vbr) + VEC_OFS));
  // R9: return restores both registers
  a_r9_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RETURN) |=> (sr_q == $past(ssr)) && (pc_q == $past(spc)));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int EVW    = 12,
  parameter int BL_POS = 28,
  parameter int RB_POS = 29,
  parameter int MD_POS = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_req,
  input  logic [EVW-1:0]  irq_code,
  input  logic            insn_brk,
  input  logic            rte_req,
  input  logic [XLEN-1:0] vbr,
  input  logic            sr_ld,
  input  logic [XLEN-1:0] sr_ld_data,
  input  logic            pc_ld,
  input  logic [XLEN-1:0] pc_ld_data,
  output logic [XLEN-1:0] sr_q,
  output logic [XLEN-1:0] pc_q,
  output logic [XLEN-1:0] ssr_q,
  output logic [XLEN-1:0] spc_q,
  output logic [EVW-1:0]  evt_q,
  output logic [EVW-1:0]  evt2_q,
  output logic            irq_taken
);
  logic    rst_meta, rst_sync_n;
  exc_op_e op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  exc_accept_ctl #(.XLEN(XLEN), .BL_POS(BL_POS)) i_ctl (
    .clk(clk), .rst_n(rst_sync_n), .irq_req(irq_req), .insn_brk(insn_brk),
    .rte_req(rte_req), .sr_cur(sr_q), .op(op), .irq_taken(irq_taken)
  );

  exc_save_bank #(.XLEN(XLEN), .EVW(EVW)) i_bank (
    .clk(clk), .rst_n(rst_sync_n), .op(op), .sr_cur(sr_q), .pc_cur(pc_q),
    .code(irq_code), .ssr_q(ssr_q), .spc_q(spc_q), .evt_q(evt_q), .evt2_q(evt2_q)
  );

  exc_live_regs #(.XLEN(XLEN), .BL_POS(BL_POS), .RB_POS(RB_POS), .MD_POS(MD_POS)) i_live (
    .clk(clk), .rst_n(rst_sync_n), .op(op), .vbr(vbr), .ssr(ssr_q), .spc(spc_q),
    .sr_ld(sr_ld), .sr_ld_data(sr_ld_data), .pc_ld(pc_ld), .pc_ld_data(pc_ld_data),
    .sr_q(sr_q), .pc_q(pc_q)
  );

  // R11: a pipeline load never clears the block bit during an entry
  a_r11_entry_beats_load: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op == OP_ENTER && sr_ld) |=> sr_q[BL_POS]);
endmodule

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        irq_req, insn_brk, rte_req, sr_ld, pc_ld;
  logic [11:0] irq_code;
  logic [31:0] vbr, sr_ld_data, pc_ld_data;
  logic [31:0] sr_q, pc_q, ssr_q, spc_q;
  logic [11:0] evt_q, evt2_q;
  logic        irq_taken;
  int          checks = 0;
  int          errors = 0;

  localparam logic [31:0] CTRL = 32'h7000_0000;
  localparam int NV = 6;
  localparam logic [31:0] V_SR  [NV] = '{32'h0000_00F0, 32'h4000_0030, 32'h0000_0050,
                                          32'h1000_0070, 32'h0000_0301, 32'h0000_0000};
  localparam logic [31:0] V_PC  [NV] = '{32'h0000_1000, 32'h0000_2468, 32'h0C00_0004,
                                          32'h0000_0888, 32'hFFFF_FFF0, 32'h0000_0010};
  localparam logic [31:0] V_VBR [NV] = '{32'h8000_0000, 32'h0000_0000, 32'h1234_0000,
                                          32'h0000_4000, 32'hFFFF_FC00, 32'h0000_0100};
  localparam logic [11:0] V_EVT [NV] = '{12'h3A0, 12'h5C0, 12'h7E0, 12'h9A0, 12'hFE0, 12'h200};
  localparam logic        V_IRQ [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam logic        V_BRK [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};

  always #4 clk = ~clk;

  exc_entry_seq i_exc_entry_seq (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_code(irq_code), .insn_brk(insn_brk),
    .rte_req(rte_req), .vbr(vbr), .sr_ld(sr_ld), .sr_ld_data(sr_ld_data), .pc_ld(pc_ld),
    .pc_ld_data(pc_ld_data), .sr_q(sr_q), .pc_q(pc_q), .ssr_q(ssr_q), .spc_q(spc_q),
    .evt_q(evt_q), .evt2_q(evt2_q), .irq_taken(irq_taken)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    irq_req = 0; insn_brk = 0; rte_req = 0; sr_ld = 0; pc_ld = 0;
  endtask

  task automatic load(input logic [31:0] s, input logic [31:0] p);
    idle(); sr_ld = 1; sr_ld_data = s; pc_ld = 1; pc_ld_data = p;
    step();
    idle();
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(); irq_code = '0; vbr = '0; sr_ld_data = '0; pc_ld_data = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 sr", sr_q, 32'h7000_00F0);
    chk("R1 pc", pc_q, 32'h0);
    chk("R1 ssr", ssr_q, 32'h0);
    chk("R1 evt", {20'h0, evt_q}, 32'h0);
    chk("R1 taken", {31'h0, irq_taken}, 32'h0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // vector table: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic take;
      logic [31:0] old_ssr, old_spc;
      load(V_SR[i], V_PC[i]);
      old_ssr = ssr_q; old_spc = spc_q;
      take = V_IRQ[i] && V_BRK[i] && !V_SR[i][28];
      irq_req = V_IRQ[i]; insn_brk = V_BRK[i]; vbr = V_VBR[i]; irq_code = V_EVT[i];
      step();
      idle();
      chk("R2 taken", {31'h0, irq_taken}, {31'h0, take});
      chk("R5 R7 sr", sr_q, take ? (V_SR[i] | CTRL) : V_SR[i]);
      chk("R6 pc", pc_q, take ? (V_VBR[i] + 32'h600) : V_PC[i]);
      chk("R4 R8 ssr", ssr_q, take ? V_SR[i] : old_ssr);
      chk("R4 R8 spc", spc_q, take ? V_PC[i] : old_spc);
      if (take) begin
        chk("R3 evt", {20'h0, evt_q}, {20'h0, V_EVT[i]});
        chk("R3 evt2", {20'h0, evt2_q}, {20'h0, V_EVT[i]});
      end
      step();
      chk("R2 pulse ends", {31'h0, irq_taken}, 32'h0);
    end

    // R8: nested request while inside handler (block bit set by entry)
    load(32'h0000_00A0, 32'h0000_0040);
    vbr = 32'h0000_2000; irq_code = 12'h111; irq_req = 1; insn_brk = 1;
    step();
    irq_code = 12'h222; vbr = 32'h0000_5000;
    step();
    idle();
    chk("R8 taken", {31'h0, irq_taken}, 32'h0);
    chk("R8 evt", {20'h0, evt_q}, 32'h111);
    chk("R8 ssr", ssr_q, 32'h0000_00A0);
    chk("R8 pc", pc_q, 32'h0000_2600);

    // R9: return restores context
    rte_req = 1;
    step();
    idle();
    chk("R9 sr", sr_q, 32'h0000_00A0);
    chk("R9 pc", pc_q, 32'h0000_0040);

    // R10: return coincides with an acceptable request
    load(32'h0000_0010, 32'h0000_0300);
    rte_req = 1; irq_req = 1; insn_brk = 1; irq_code = 12'h333; vbr = 32'h0000_7000;
    step();
    idle();
    chk("R10 sr", sr_q, 32'h0000_00A0);
    chk("R10 pc", pc_q, 32'h0000_0040);
    chk("R10 taken", {31'h0, irq_taken}, 32'h0);
    chk("R10 evt", {20'h0, evt_q}, 32'h111);
    irq_req = 1; insn_brk = 1;
    step();
    idle();
    chk("R10 retake", {31'h0, irq_taken}, 32'h1);
    chk("R10 evt new", {20'h0, evt_q}, 32'h333);
    chk("R10 spc", spc_q, 32'h0000_0040);

    // R11: load ignored under entry, honoured otherwise
    load(32'h0000_0060, 32'h0000_0900);
    chk("R11 plain load sr", sr_q, 32'h0000_0060);
    chk("R11 plain load pc", pc_q, 32'h0000_0900);
    irq_req = 1; insn_brk = 1; vbr = 32'h0;
    sr_ld = 1; sr_ld_data = 32'h0000_0005; pc_ld = 1; pc_ld_data = 32'h0000_0ABC;
    step();
    idle();
    chk("R11 entry wins sr", sr_q, 32'h7000_0060);
    chk("R11 entry wins pc", pc_q, 32'h0000_0600);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule